// File: doc/BRIEF.md
# Pipelined Rectangular-to-Polar Converter

This block turns a Cartesian pair (X, Y) into a magnitude and a phase angle. It is built as a fully pipelined iterative-rotation (CORDIC vectoring) datapath. It accepts a new pair on every clock and returns each result after a fixed number of register stages.

The two 16-bit coordinates each sit behind their own capture register, and each register has its own load enable. A static format select decides how both coordinates are read: as two's complement or as sign-magnitude. Before the rotation stages, the vector is folded into the right half-plane. The half-plane is restored on the phase afterwards. The rotation gain is removed with a constant multiply, and the magnitude is rounded to the nearest integer. A valid bit travels beside the data so the consumer can align results with their inputs.

Top module: `rect_to_polar`

## Requirements
- R1: With `fmt_sm` low, `x_in` and `y_in` are two's complement values. With `fmt_sm` high, bit 15 is the sign (1 means negative) and bits 14..0 are the magnitude.
- R2: `mag_out` is the unsigned value of sqrt(X²+Y²) rounded to the nearest integer, within ±1. It never exceeds 46341 and needs no overflow flag.
- R3: `phase_out` is atan2(Y, X) expressed in units of pi: 0x4000 is +pi/2, 0x8000 is ±pi and 0xC000 is -pi/2, and one LSB is 2^-15·pi. The value is round(atan2/pi·32768) modulo 65536, within ±2 LSB.
- R4: A pair captured at rising edge k appears on the outputs right after edge k+21, which is 22 register stages. `out_vld` repeats the `in_vld` that was sampled at edge k. A new result arrives on every clock.
- R5: `x_in` is loaded only on an edge where `x_en` is high, and `y_in` only where `y_en` is high. While an enable is low, the held value keeps feeding the datapath.
- R6: In sign-magnitude format, code 0x8000 is treated as zero and code 0xFFFF as -32767.
- R7: An input that decodes to (0, 0) gives a magnitude of 0 and a phase of 0.
- R8: Vectors with a negative X get a phase in the second or third quadrant. For example, (-32768, 0) gives phase 0x8000 and magnitude 32768.
- R9: While `rst_n` is low, `out_vld`, `mag_out` and `phase_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sm | input | 1 | Coordinate format: 0 two's complement, 1 sign-magnitude (static) |
| x_en | input | 1 | Load enable of the X capture register |
| y_en | input | 1 | Load enable of the Y capture register |
| in_vld | input | 1 | Marks the current cycle's pair as meaningful |
| x_in | input | 16 | X coordinate |
| y_in | input | 16 | Y coordinate |
| mag_out | output | 16 | Unsigned rounded magnitude |
| phase_out | output | 16 | Phase, scaled so that 0x8000 is pi |
| out_vld | output | 1 | Valid bit aligned with `mag_out` and `phase_out` |

## Verification
The main function is tried first with vectors on the four half-axes and the four diagonals. These show whether the half-plane fold and the later phase restoration pick the right quadrant, including the ±pi seam. Full-scale corners, such as two's complement (-32768, -32768), stress the magnitude range and the rounding. Tiny vectors such as (1, 1) show whether the fractional guard bits are enough for the phase. Long random runs in both formats, with random enables and valid gaps, separate a correct latency and enable hold from an off-by-one in the pipeline. The sign-magnitude codes 0x8000 and 0xFFFF are driven on purpose to tell negative zero apart from the largest negative value.

// File: rtl/rect_to_polar.sv
module rect_to_polar #(
  parameter int DW   = 16,
  parameter int ITER = 18,
  parameter int FRAC = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fmt_sm,
  input  logic          x_en,
  input  logic          y_en,
  input  logic          in_vld,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] y_in,
  output logic [DW-1:0] mag_out,
  output logic [DW-1:0] phase_out,
  output logic          out_vld
);
  localparam int AW  = 24;
  localparam int W   = DW + FRAC + 4;
  localparam int MW  = W + 17;
  localparam int LAT = ITER + 4;
  localparam logic [16:0] GAIN_Q16 = 17'd39797;
  localparam logic signed [W-1:0] YBOUND = W'(64'd1 << (FRAC + 4));

  // angle of step k; 2^AW is a full turn
  function automatic logic [AW-1:0] atan_step(input int k);
    case (k)
      0: atan_step = 24'd2097152;
      1: atan_step = 24'd1238021;
      2: atan_step = 24'd654136;
      3: atan_step = 24'd332050;
      4: atan_step = 24'd166669;
      5: atan_step = 24'd83416;
      6: atan_step = 24'd41718;
      7: atan_step = 24'd20860;
      8: atan_step = 24'd10430;
      default: atan_step = 24'd2670177 >> k;
    endcase
  endfunction

  function automatic logic signed [DW:0] dec(input logic [DW-1:0] v, input logic sm);
    logic signed [DW:0] m;
    m = $signed({2'b00, v[DW-2:0]});
    if (sm) dec = v[DW-1] ? -m : m;
    else    dec = $signed({v[DW-1], v});
  endfunction

  logic [DW-1:0]        xr, yr;
  logic [LAT-1:0]       vp;
  logic signed [DW:0]   xd, yd, xf, yf;
  logic signed [W-1:0]  xs [0:ITER];
  logic signed [W-1:0]  ys [0:ITER];
  logic [AW-1:0]        zs [0:ITER];
  logic [ITER:0]        lf, zf;
  logic [MW-1:0]        prod, mrnd, msh;
  logic [DW-1:0]        pz;
  logic                 pl, pzr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xr <= '0;
      yr <= '0;
    end else begin
      if (x_en) xr <= x_in;
      if (y_en) yr <= y_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vp <= '0;
    else        vp <= {vp[LAT-2:0], in_vld};
  end
  assign out_vld = vp[LAT-1];

  assign xd = dec(xr, fmt_sm);
  assign yd = dec(yr, fmt_sm);
  assign xf = xd[DW] ? -xd : xd;
  assign yf = xd[DW] ? -yd : yd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= ITER; i++) begin
        xs[i] <= '0;
        ys[i] <= '0;
        zs[i] <= '0;
      end
      lf <= '0;
      zf <= '0;
    end else begin
      xs[0] <= {{(W-DW-1-FRAC){xf[DW]}}, xf, {FRAC{1'b0}}};
      ys[0] <= {{(W-DW-1-FRAC){yf[DW]}}, yf, {FRAC{1'b0}}};
      zs[0] <= '0;
      lf[0] <= xd[DW];
      zf[0] <= (xd == '0) && (yd == '0);
      for (int i = 0; i < ITER; i++) begin
        if (ys[i][W-1]) begin
          xs[i+1] <= xs[i] - (ys[i] >>> i);
          ys[i+1] <= ys[i] + (xs[i] >>> i);
          zs[i+1] <= zs[i] - atan_step(i);
        end else begin
          xs[i+1] <= xs[i] + (ys[i] >>> i);
          ys[i+1] <= ys[i] - (xs[i] >>> i);
          zs[i+1] <= zs[i] + atan_step(i);
        end
        lf[i+1] <= lf[i];
        zf[i+1] <= zf[i];
      end
    end
  end

  assign mrnd = prod + (MW'(1) << (FRAC + 15));
  assign msh  = mrnd >> (FRAC + 16);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod      <= '0;
      pz        <= '0;
      pl        <= 1'b0;
      pzr       <= 1'b0;
      mag_out   <= '0;
      phase_out <= '0;
    end else begin
      prod      <= MW'(xs[ITER]) * MW'(GAIN_Q16);
      pz        <= zs[ITER][AW-1 -: DW] + DW'(zs[ITER][AW-DW-1]);
      pl        <= lf[ITER];
      pzr       <= zf[ITER];
      mag_out   <= (|msh[MW-1:DW]) ? '1 : msh[DW-1:0];
      phase_out <= pzr ? '0 : pz + (pl ? {1'b1, {(DW-1){1'b0}}} : '0);
    end
  end

  assert_hold_x_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !x_en |=> $stable(xr));
  assert_hold_y_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !y_en |=> $stable(yr));
  assert_residual_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vp[ITER+1] |-> (ys[ITER] < YBOUND) && (ys[ITER] > -YBOUND));
  assert_zero_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && mag_out == '0) |-> phase_out == '0);
  assert_mag_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> mag_out <= DW'(46341));
endmodule

// File: tb/rect_to_polar_bench.sv
module rect_to_polar_bench;
  localparam int  CLK_PERIOD = 10;
  localparam int  LAT = 22;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0, rst_n = 1'b0, fmt_sm = 1'b0;
  logic x_en = 1'b0, y_en = 1'b0, in_vld = 1'b0;
  logic [15:0] x_in = '0, y_in = '0;
  logic [15:0] mag_out, phase_out;
  logic out_vld;

  int checks = 0, failures = 0, pe = 0;
  bit done = 0;
  int em [4096];
  int ep [4096];
  bit ev [4096];
  string et [4096];
  logic [15:0] mx = '0, my = '0;

  rect_to_polar u_rect_to_polar (
    .clk(clk), .rst_n(rst_n), .fmt_sm(fmt_sm), .x_en(x_en), .y_en(y_en),
    .in_vld(in_vld), .x_in(x_in), .y_in(y_in),
    .mag_out(mag_out), .phase_out(phase_out), .out_vld(out_vld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) pe <= pe + 1;

  function automatic int decode(logic [15:0] v, bit sm);
    int m;
    if (sm) begin
      m = int'(v[14:0]);
      return v[15] ? -m : m;
    end
    return int'($signed(v));
  endfunction

  function automatic int ref_mag(int x, int y);
    real r;
    r = $sqrt(real'(x) * real'(x) + real'(y) * real'(y));
    return $rtoi(r + 0.5);
  endfunction

  function automatic int ref_ph(int x, int y);
    real p;
    if (x == 0 && y == 0) return 0;
    p = $atan2(real'(y), real'(x)) / PI * 32768.0;
    return $rtoi($floor(p + 0.5)) & 65535;
  endfunction

  task automatic chk(string tag, string what, int got, int exp, bit ok);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  task automatic check_out();
    int k, dm, dp;
    k = (pe - (LAT - 1)) & 4095;
    chk("R4", "valid", int'(out_vld), int'(ev[k]), out_vld === ev[k]);
    if (ev[k]) begin
      dm = int'(mag_out) - em[k];
      chk(et[k], "magnitude", int'(mag_out), em[k], dm <= 1 && dm >= -1);
      dp = (int'(phase_out) - ep[k]) & 65535;
      if (dp > 32767) dp -= 65536;
      chk(et[k], "phase", int'(phase_out), ep[k], dp <= 2 && dp >= -2);
    end
  endtask

  task automatic step(int xi, int yi, bit xe, bit ye, bit v, string tag);
    int k, xv, yv;
    check_out();
    x_in = 16'(xi); y_in = 16'(yi);
    x_en = xe; y_en = ye; in_vld = v;
    if (xe) mx = 16'(xi);
    if (ye) my = 16'(yi);
    k = (pe + 1) & 4095;
    xv = decode(mx, fmt_sm);
    yv = decode(my, fmt_sm);
    ev[k] = v; et[k] = tag;
    em[k] = ref_mag(xv, yv);
    ep[k] = ref_ph(xv, yv);
    @(negedge clk);
  endtask

  task automatic rand_run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      int xi, yi;
      xi = int'($urandom & 32'hFFFF);
      yi = int'($urandom & 32'hFFFF);
      if (($urandom % 4) == 0) xi = int'($urandom % 33) - 16;
      if (($urandom % 4) == 0) yi = int'($urandom % 33) - 16;
      step(xi, yi, ($urandom % 8) != 0, ($urandom % 8) != 0, ($urandom % 4) != 0, tag);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog run did not finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 4096; i++) ev[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "reset valid", int'(out_vld), 0, out_vld === 1'b0);
    chk("R9", "reset magnitude", int'(mag_out), 0, mag_out === 16'd0);
    chk("R9", "reset phase", int'(phase_out), 0, phase_out === 16'd0);
    rst_n = 1'b1;

    // two's complement, directed
    step(0, 0, 1, 1, 1, "R7");
    step(100, 0, 1, 1, 1, "R3");
    step(0, 100, 1, 1, 1, "R3");
    step(0, -100, 1, 1, 1, "R3");
    step(1, 1, 1, 1, 1, "R3");
    step(-100, 0, 1, 1, 1, "R8");
    step(-32768, 0, 1, 1, 1, "R8");
    step(-3, 4, 1, 1, 1, "R8");
    step(-3, -4, 1, 1, 1, "R8");
    step(3, 4, 1, 1, 1, "R2");
    step(-32768, -32768, 1, 1, 1, "R2");
    step(32767, 32767, 1, 1, 1, "R2");
    step(-1, 32767, 1, 1, 1, "R1");
    // enable hold
    step(1000, 0, 1, 1, 1, "R5");
    step(-5000, 2000, 0, 1, 1, "R5");
    step(7, -9000, 1, 0, 1, "R5");
    step(123, 456, 0, 0, 1, "R5");
    step(0, 0, 1, 1, 0, "R4");
    step(500, 500, 1, 1, 1, "R4");
    rand_run(300, "R1");
    repeat (25) step(0, 0, 0, 0, 0, "R4");

    // sign-magnitude
    fmt_sm = 1'b1;
    step(16'h8000, 16'h8000, 1, 1, 1, "R6");
    step(16'hFFFF, 0, 1, 1, 1, "R6");
    step(16'h8000, 5, 1, 1, 1, "R6");
    step(0, 16'hFFFF, 1, 1, 1, "R6");
    step(16'h8064, 16'h0064, 1, 1, 1, "R1");
    step(16'h7FFF, 16'hFFFF, 1, 1, 1, "R1");
    step(16'h8003, 16'h8004, 1, 1, 1, "R8");
    rand_run(300, "R6");
    repeat (25) step(0, 0, 0, 0, 0, "R4");

    summary();
    $finish;
  end
endmodule